// File: doc/BRIEF.md
# Configuration Record Checksum Scanner

This block reads a small identity record out of a byte-wide non-volatile memory, checks that it is genuine and, when it is, hands the 48-bit hardware address it holds to the rest of the chip. The record is a run of 16-bit words stored as byte pairs, with the even byte taken as the high byte. Its first word is a fixed marker, and the word that follows the summed words holds an additive check value. A second copy of the record sits at a fixed distance from the first. The block tries the first copy and falls back to the second only when the first is rejected.

Software or a boot sequencer pulses `start`. The block raises `busy`, walks the record one byte at a time over a simple read port, and ends the scan with a single-cycle `done` pulse. At that pulse `valid` tells whether either copy was accepted, and `mac` carries the address from the accepted copy. The read port has no stall path. The memory must return data within the fixed strobe window, and the block never applies back-pressure on the port. Each byte costs a fixed number of cycles, so a full scan takes a bounded, known time.

Top module: `cookie_scan`

## Requirements
- R1: A copy is accepted only if its word 0, taken from bytes 0 (high) and 1 (low), equals 0x8D74.
- R2: A copy is accepted only if its word 17, at bytes 0x22 (high) and 0x23 (low), equals the sum modulo 2^16 of words 0 to 16.
- R3: On acceptance, `mac` holds bytes 4 to 9 of the accepted copy, with byte 4 in bits 47:40 and byte 9 in bits 7:0.
- R4: The first read of a scan is at `BASE_ADDR`. The copy at `BASE_ADDR + 0x280` is read only when the first copy is rejected. `valid` is 0 at `done` only when both copies are rejected.
- R5: A copy whose word 0 mismatches is abandoned after its first two bytes. A fully checked copy costs exactly 36 byte reads.
- R6: Every byte read holds `mem_rd` high for exactly `RD_HOLD` consecutive cycles with `mem_addr` stable, and `mem_rd` goes low between reads.
- R7: `mac` changes only in the cycle where `done` and `valid` are both 1. A scan that rejects both copies leaves `mac` at its previous value.
- R8: `done` is a one-cycle pulse with `busy` low. `busy` covers the whole scan, and `start` is ignored while `busy` is high.
- R9: After reset, `busy`, `done`, `valid` and `mem_rd` are 0 and `mac` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a scan; ignored while busy |
| busy | output | 1 | High while a scan is in progress |
| done | output | 1 | One-cycle pulse at the end of a scan |
| valid | output | 1 | Result of the last scan; cleared when a scan starts |
| mac | output | 48 | Address taken from the last accepted copy |
| mem_addr | output | ADDR_W | Byte address toward the memory |
| mem_rd | output | 1 | Read strobe, held RD_HOLD cycles per byte |
| mem_data | input | 8 | Byte returned by the memory, sampled on the last strobe cycle |

## Verification
The assertions check the read strobe's shape every cycle: its exact length, a stable address while the strobe is high, and the low gap between reads. They also check that every address falls inside one of the two record windows, that `done` is a lone pulse outside `busy`, and that `mac` never moves except at an accepting `done`. Only the bench scenarios can show that the marker and checksum decisions are correct, including a checksum that wraps past 16 bits. The same holds for the fallback order, the early abandon after a bad marker, the exact number of reads per outcome, and that a second `start` during a scan is ignored.

// File: rtl/cookie_pkg.sv
package cookie_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_PACK,
    ST_JUDGE
  } scan_st_t;

  typedef logic [7:0]  byte_t;
  typedef logic [15:0] word_t;
endpackage

// File: rtl/cookie_rd_port.sv
module cookie_rd_port
  import cookie_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int RD_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  byte_t             mem_data,
  output logic              byte_vld,
  output byte_t             byte_q
);
  localparam int CW = $clog2(RD_HOLD + 1);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      hold_cnt <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!mem_rd) begin
        if (req) begin
          mem_rd   <= 1'b1;
          mem_addr <= req_addr;
          hold_cnt <= '0;
        end
      end else if (hold_cnt == CW'(RD_HOLD - 1)) begin
        mem_rd   <= 1'b0;
        byte_vld <= 1'b1;
        byte_q   <= mem_data;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cookie_word_pack.sv
module cookie_word_pack
  import cookie_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_vld,
  input  byte_t            byte_in,
  output logic             word_vld,
  output word_t            word,
  output logic [IDX_W-1:0] word_idx
);
  byte_t            hi_q;
  logic             odd_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q     <= '0;
      odd_q    <= 1'b0;
      idx_q    <= '0;
      word_vld <= 1'b0;
      word     <= '0;
      word_idx <= '0;
    end else if (clr) begin
      odd_q    <= 1'b0;
      idx_q    <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (byte_vld) begin
        if (!odd_q) begin
          hi_q  <= byte_in;
          odd_q <= 1'b1;
        end else begin
          word     <= {hi_q, byte_in};
          word_idx <= idx_q;
          word_vld <= 1'b1;
          idx_q    <= idx_q + 1'b1;
          odd_q    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cookie_sum_chk.sv
module cookie_sum_chk
  import cookie_pkg::*;
#(
  parameter int          IDX_W     = 5,
  parameter int          SUM_WORDS = 17,
  parameter logic [15:0] MAGIC     = 16'h8D74,
  parameter int          MAC_WORD  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             word_vld,
  input  word_t            word,
  input  logic [IDX_W-1:0] word_idx,
  output logic             fin,
  output logic             ok,
  output logic [47:0]      mac_shadow
);
  word_t sum_q;
  logic  is_cks_word;
  logic  is_mac_word;

  assign is_cks_word = (word_idx == IDX_W'(SUM_WORDS));
  assign is_mac_word = (word_idx >= IDX_W'(MAC_WORD)) &&
                       (word_idx <  IDX_W'(MAC_WORD + 3));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q      <= '0;
      fin        <= 1'b0;
      ok         <= 1'b0;
      mac_shadow <= '0;
    end else if (clr) begin
      sum_q <= '0;
      fin   <= 1'b0;
      ok    <= 1'b0;
    end else if (word_vld && !fin) begin
      if (is_cks_word) begin
        fin <= 1'b1;
        ok  <= (word == sum_q);
      end else begin
        sum_q <= sum_q + word;
        if (word_idx == '0 && word != MAGIC) begin
          fin <= 1'b1;
          ok  <= 1'b0;
        end
        if (is_mac_word) mac_shadow <= {mac_shadow[31:0], word};
      end
    end
  end
endmodule

// File: rtl/cookie_scan.sv
module cookie_scan
  import cookie_pkg::*;
#(
  parameter int          ADDR_W      = 13,
  parameter int          BASE_ADDR   = 0,
  parameter int          ALT_OFFSET  = 'h280,
  parameter int          RD_HOLD     = 3,
  parameter logic [15:0] MAGIC       = 16'h8D74,
  parameter int          SUM_WORDS   = 17,
  parameter int          MAC_WORD    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              valid,
  output logic [47:0]       mac,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_data
);
  localparam int REC_BYTES = 2 * (SUM_WORDS + 1);
  localparam int IDX_W     = $clog2(SUM_WORDS + 1);
  localparam int BI_W      = $clog2(REC_BYTES);

  scan_st_t          st_q;
  logic              alt_q;
  logic [BI_W-1:0]   byte_i;
  logic              req;
  logic [ADDR_W-1:0] req_addr;
  logic              clr;
  logic              byte_vld;
  byte_t             byte_q;
  logic              word_vld;
  word_t             word;
  logic [IDX_W-1:0]  word_idx;
  logic              rec_fin;
  logic              rec_ok;
  logic [47:0]       mac_shadow;

  assign busy     = (st_q != ST_IDLE);
  assign req      = (st_q == ST_REQ);
  assign req_addr = ADDR_W'(BASE_ADDR) + (alt_q ? ADDR_W'(ALT_OFFSET) : '0) +
                    ADDR_W'(byte_i);
  assign clr      = (st_q == ST_IDLE && start) ||
                    (st_q == ST_JUDGE && rec_fin && !rec_ok && !alt_q);

  cookie_rd_port #(.ADDR_W(ADDR_W), .RD_HOLD(RD_HOLD)) i_rd_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .req_addr (req_addr),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_data (mem_data),
    .byte_vld (byte_vld),
    .byte_q   (byte_q)
  );

  cookie_word_pack #(.IDX_W(IDX_W)) i_word_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .byte_vld (byte_vld),
    .byte_in  (byte_q),
    .word_vld (word_vld),
    .word     (word),
    .word_idx (word_idx)
  );

  cookie_sum_chk #(
    .IDX_W(IDX_W), .SUM_WORDS(SUM_WORDS), .MAGIC(MAGIC), .MAC_WORD(MAC_WORD)
  ) i_sum_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .word_vld   (word_vld),
    .word       (word),
    .word_idx   (word_idx),
    .fin        (rec_fin),
    .ok         (rec_ok),
    .mac_shadow (mac_shadow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      alt_q  <= 1'b0;
      byte_i <= '0;
      done   <= 1'b0;
      valid  <= 1'b0;
      mac    <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            alt_q  <= 1'b0;
            byte_i <= '0;
            valid  <= 1'b0;
            st_q   <= ST_REQ;
          end
        end
        ST_REQ:  st_q <= ST_WAIT;
        ST_WAIT: begin
          if (byte_vld) begin
            byte_i <= byte_i + 1'b1;
            st_q   <= ST_PACK;
          end
        end
        ST_PACK: st_q <= ST_JUDGE;
        ST_JUDGE: begin
          if (rec_fin) begin
            if (rec_ok || alt_q) begin
              done  <= 1'b1;
              valid <= rec_ok;
              if (rec_ok) mac <= mac_shadow;
              st_q  <= ST_IDLE;
            end else begin
              alt_q  <= 1'b1;
              byte_i <= '0;
              st_q   <= ST_REQ;
            end
          end else begin
            st_q <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cookie_scan_chk.sv
module cookie_scan_chk #(
  parameter int ADDR_W     = 13,
  parameter int BASE_ADDR  = 0,
  parameter int ALT_OFFSET = 'h280,
  parameter int RD_HOLD    = 3,
  parameter int SUM_WORDS  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              valid,
  input logic [47:0]       mac,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd
);
  localparam int REC_BYTES = 2 * (SUM_WORDS + 1);
  localparam int RW        = $clog2(RD_HOLD + 2);

  logic [RW-1:0]     run_q;
  logic [ADDR_W-1:0] off_pri;
  logic [ADDR_W-1:0] off_alt;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (mem_rd) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assign off_pri = mem_addr - ADDR_W'(BASE_ADDR);
  assign off_alt = off_pri - ADDR_W'(ALT_OFFSET);

  assert_strobe_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd) |-> run_q == RW'(RD_HOLD));
  assert_strobe_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> run_q < RW'(RD_HOLD));
  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && run_q != '0) |-> $stable(mem_addr));
  assert_addr_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (off_pri < ADDR_W'(REC_BYTES) || off_alt < ADDR_W'(REC_BYTES)));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd);
  assert_mac_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mac) |-> (done && valid));
endmodule

bind cookie_scan cookie_scan_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ALT_OFFSET(ALT_OFFSET),
  .RD_HOLD(RD_HOLD), .SUM_WORDS(SUM_WORDS)
) i_cookie_scan_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .valid    (valid),
  .mac      (mac),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd)
);

// File: tb/test_cookie_scan.sv
module test_cookie_scan;
  localparam int ALT = 'h280;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, valid;
  logic [47:0] mac;
  logic [12:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data;
  logic [7:0]  mem [0:1023];

  int checks = 0;
  int fails  = 0;
  int dones  = 0;

  typedef struct {
    logic        v;
    logic [47:0] m;
    int          reads;
    logic        alt;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  assign mem_data = mem[mem_addr[9:0]];

  cookie_scan i_cookie_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .valid(valid), .mac(mac), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_data(mem_data)
  );

  task automatic check(input bit cond, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Build one record copy; bytes stored high byte first.
  task automatic build(input int base, input logic [47:0] m, input logic [15:0] seed,
                       input bit bad_magic, input bit bad_sum);
    logic [15:0] w [0:17];
    logic [15:0] s;
    w[0] = bad_magic ? 16'h8D75 : 16'h8D74;
    w[1] = seed;
    w[2] = m[47:32];
    w[3] = m[31:16];
    w[4] = m[15:0];
    for (int k = 5; k < 17; k++) w[k] = seed + 16'(k * 'h1F3D);
    s = '0;
    for (int k = 0; k < 17; k++) s = s + w[k];
    w[17] = bad_sum ? s + 16'd1 : s;
    for (int k = 0; k < 18; k++) begin
      mem[base + 2*k]     = w[k][15:8];
      mem[base + 2*k + 1] = w[k][7:0];
    end
  endtask

  logic [47:0] last_mac = '0;

  task automatic run_case(input logic [47:0] m1, input bit pbm, input bit pbs,
                          input logic [47:0] m2, input bit sbm, input bit sbs,
                          input logic [15:0] seed, input bit double_start);
    exp_t e;
    bit   pri_ok, sec_ok;
    build(0, m1, seed, pbm, pbs);
    build(ALT, m2, seed ^ 16'hA5A5, sbm, sbs);
    pri_ok = !pbm && !pbs;
    sec_ok = !sbm && !sbs;
    if (pri_ok) begin
      e.v = 1'b1; e.m = m1; e.reads = 36; e.alt = 1'b0;
    end else begin
      e.v = sec_ok;
      e.m = sec_ok ? m2 : last_mac;
      e.reads = (pbm ? 2 : 36) + (sbm ? 2 : 36);
      e.alt = 1'b1;
    end
    last_mac = e.m;
    sb_q.push_back(e);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
    if (double_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: strobe shape, read counts, scoreboard compare at done.
  int          nreads = 0;
  int          run = 0;
  bit          prev_rd = 1'b0;
  bit          first = 1'b1;
  bit          alt_seen = 1'b0;
  logic [12:0] first_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd && !prev_rd) begin
        nreads++;
        if (first) first_addr = mem_addr;
        first = 1'b0;
        if (mem_addr >= 13'(ALT)) alt_seen = 1'b1;
      end
      if (mem_rd) run++;
      else if (prev_rd) begin
        check(run == 3, "R6", "strobe length", 64'(run), 64'd3);
        run = 0;
      end
      if (done) begin
        exp_t e;
        dones++;
        check(busy == 1'b0, "R8", "busy at done", 64'(busy), 64'd0);
        if (sb_q.size() == 0) begin
          check(1'b0, "R8", "unexpected done", 64'd1, 64'd0);
        end else begin
          e = sb_q.pop_front();
          check(valid == e.v, "R4", "valid", 64'(valid), 64'(e.v));
          check(mac == e.m, "R3 R7", "mac", 64'(mac), 64'(e.m));
          check(nreads == e.reads, "R5", "byte reads", 64'(nreads), 64'(e.reads));
          check(alt_seen == e.alt, "R4", "second copy used", 64'(alt_seen), 64'(e.alt));
          check(first_addr == 13'd0, "R4", "first address", 64'(first_addr), 64'd0);
        end
        nreads = 0; first = 1'b1; alt_seen = 1'b0;
      end
      prev_rd = mem_rd;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(busy == 1'b0 && done == 1'b0, "R9", "busy/done", 64'({busy, done}), 64'd0);
    check(valid == 1'b0, "R9", "valid", 64'(valid), 64'd0);
    check(mac == 48'd0 && mem_rd == 1'b0, "R9", "mac/strobe", 64'(mac), 64'd0);

    // R1 R2 R3: primary good
    run_case(48'h0005_324A_2C9C, 0, 0, 48'h1111_2222_3333, 0, 0, 16'h0101, 0);
    // R2 R4: primary checksum bad, secondary good
    run_case(48'hAAAA_BBBB_CCCC, 0, 1, 48'h0200_0000_00F1, 0, 0, 16'hF00D, 0);
    // R1 R5: primary marker bad, secondary good
    run_case(48'h0102_0304_0506, 1, 0, 48'hDEAD_BEEF_0042, 0, 0, 16'h7777, 0);
    // R7: both checksums bad, mac keeps previous
    run_case(48'h9999_8888_7777, 0, 1, 48'h6666_5555_4444, 0, 1, 16'h1234, 0);
    // R5: both markers bad
    run_case(48'h1212_3434_5656, 1, 0, 48'h7878_9A9A_BCBC, 1, 0, 16'h4321, 0);
    // R2: heavy wrap of the 16-bit sum
    run_case(48'hFFFF_FFFF_FFFE, 0, 0, 48'h0, 0, 0, 16'hFFFF, 0);
    // R8: second start during busy is ignored
    run_case(48'h00AB_CDEF_0123, 0, 1, 48'h0C0F_FEE0_0001, 0, 0, 16'h5A5A, 1);
    check(dones == 7, "R8", "done count", 64'(dones), 64'd7);
    check(sb_q.size() == 0, "R8", "pending results", 64'(sb_q.size()), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule